// File: doc/BRIEF.md
# Dual-Mode Demodulated Word Extractor

This block sits behind an FSK demodulator. It takes the recovered serial bit stream, finds asynchronous character frames in it (a low start bit, eight data bits with the least significant bit first, then one or more high stop bits), and hands each data byte to a host over three wires: a serial data line, a data clock and a data-ready flag. The nominal line rate is 1200 baud. The block samples the line at sixteen times the bit rate, using a sample tick divided down from the system clock.

A mode input selects the behaviour of the host link. With the mode low, the block drives the link itself. The data line carries the demodulated stream directly, and data-ready pulses for one clock each time a stop bit is validated. With the mode high, the host pulls the data. A validated byte is held, data-ready rises, and each rising edge of the host-driven data clock moves the data line on to the next bit. Data-ready falls after the eighth edge.

The block also drives the enable that gates the demodulator. This enable drops when the carrier, once present, is lost. It also drops once the number of bytes given by the message-length byte (the second byte of a message) has arrived. While the enable is low, incoming frames are ignored. A one-clock re-arm pulse from the host prepares the block for the next message.

Top module: `demod_word_extractor`

## Requirements
- R1: The line is sampled 16 times per bit. A falling edge starts a frame only if the line is still low at the middle sample of the start bit, so a low glitch shorter than half a bit produces no word.
- R2: The eight data bits are taken at their bit centres, least significant bit first. A frame whose bit period is off by up to 1.5% from nominal is still received correctly.
- R3: Any number of stop bits from 1 to 10 between characters is accepted, and frames with one stop bit may follow each other back to back.
- R4: A stop bit that samples as 0 discards the word with no data-ready. Reception resumes once the line has returned high.
- R5: In mode 0 (mode_i = 0), data_o follows bit_i two clocks later, and dr_o is a single-clock pulse for every validated frame.
- R6: In mode 1 (mode_i = 1), dr_o rises when a frame is validated and data_o shows bit 0 of the word. Each rising edge of dclk_i advances data_o to the next bit, least significant bit first.
- R7: In mode 1, dr_o falls after the eighth rising edge of dclk_i and data_o then rests at 1. Further dclk_i edges with no word held change neither output.
- R8: In mode 1, a word validated while an earlier word is still held replaces it, and the shift restarts from bit 0.
- R9: demod_en_o is 1 after reset and after a rearm_i pulse. It drops when carrier_n_i goes high after having been low since the last reset or re-arm.
- R10: The second validated byte of a message is the length. demod_en_o drops when that many further bytes have been validated, or right after the length byte if the length is 0.
- R11: Once demod_en_o is low it stays low until rearm_i, and frames arriving meanwhile produce no dr_o.
- R12: After reset dr_o is 0 and demod_en_o is 1, and in mode 1 data_o rests at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | Link mode: 0 block-driven, 1 host-clocked |
| bit_i | input | 1 | Demodulated serial stream, idle high |
| carrier_n_i | input | 1 | Carrier detect, low while carrier is present |
| rearm_i | input | 1 | One-clock pulse that re-enables the demodulator for a new message |
| dclk_i | input | 1 | Host data clock, used in mode 1 |
| data_o | output | 1 | Serial data to the host |
| dr_o | output | 1 | Data ready |
| demod_en_o | output | 1 | Enable for the demodulator |

## Verification
The bench sends a brief low glitch. A receiver that skipped the mid-start check would build a bogus word from it and raise data-ready. It sends frames whose bit period is 1.5% long or short, and frames with ten stop bits. A design that sampled at bit edges, or that expected a fixed frame length, would then return wrong bits or lose framing. It also covers a stop bit held low, a second word that lands before the first is read, a message length of zero, and frames arriving after the enable has dropped. These would show up as a stray data-ready, a stale word, an enable that never falls, or data-ready pulses while the demodulator is off.

// File: rtl/wx_pkg.sv
// Shared constants and types for the demodulated word extractor.
package wx_pkg;
    localparam int SAMPLES_PER_BIT = 16;  // oversampling ratio
    localparam int DATA_BITS       = 8;   // character width

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT_MARK
    } rx_state_e;
endpackage

// File: rtl/wx_sample_tick.sv
// Sample tick generator.
// Emits a one-clock pulse every CLKS_PER_SAMPLE clocks. It assumes the
// system clock is CLKS_PER_SAMPLE * 16 * baud rate.
module wx_sample_tick #(
    parameter int CLKS_PER_SAMPLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(CLKS_PER_SAMPLE + 1);

    logic [CW-1:0] div_q;

    // Divide the clock down to the sample rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_o <= 1'b0;
        end else if (div_q == CW'(CLKS_PER_SAMPLE - 1)) begin
            div_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            div_q  <= div_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    generate
        if (CLKS_PER_SAMPLE > 1) begin : g_spacing
            // R1: ticks are isolated pulses, so the 16 samples span a whole bit
            assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o)
                else $error("sample tick wider than one clock");
        end
    endgenerate
endmodule

// File: rtl/wx_frame_rx.sv
// Oversampled character framer.
// It waits for a falling edge and confirms the start bit at its middle
// sample. It then takes DATA_BITS bits at their centres, LSB first, and
// checks one stop bit. Extra stop bits are idle line and are skipped in
// RX_IDLE. A low stop bit raises ferr_o, and the framer waits for the line
// to go high again. It assumes rx_i is already synchronised. The framer
// stays idle while run_i is low.
module wx_frame_rx
    import wx_pkg::*;
#(
    parameter int OVS    = SAMPLES_PER_BIT,
    parameter int WORD_W = DATA_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              rx_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              ferr_o
);
    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(WORD_W);
    localparam int MID  = OVS / 2 - 1;
    localparam int LAST = OVS - 1;

    rx_state_e         state_q;
    logic [CW-1:0]     smp_q;
    logic [BW-1:0]     bit_q;
    logic [WORD_W-1:0] shift_q;

    assign word_o = shift_q;

    // Frame state machine, advanced once per sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            smp_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
            if (!run_i) begin
                state_q <= RX_IDLE;
            end else if (tick_i) begin
                case (state_q)
                    RX_IDLE: begin
                        if (!rx_i) begin
                            state_q <= RX_START;
                            smp_q   <= '0;
                        end
                    end
                    RX_START: begin
                        if (smp_q == CW'(MID)) begin
                            smp_q <= '0;
                            bit_q <= '0;
                            state_q <= rx_i ? RX_IDLE : RX_DATA;
                        end else begin
                            smp_q <= smp_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (smp_q == CW'(LAST)) begin
                            smp_q   <= '0;
                            shift_q <= {rx_i, shift_q[WORD_W-1:1]};
                            if (bit_q == BW'(WORD_W - 1)) begin
                                state_q <= RX_STOP;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end else begin
                            smp_q <= smp_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (smp_q == CW'(LAST)) begin
                            smp_q <= '0;
                            if (rx_i) begin
                                valid_o <= 1'b1;
                                state_q <= RX_IDLE;
                            end else begin
                                ferr_o  <= 1'b1;
                                state_q <= RX_WAIT_MARK;
                            end
                        end else begin
                            smp_q <= smp_q + 1'b1;
                        end
                    end
                    RX_WAIT_MARK: begin
                        if (rx_i) state_q <= RX_IDLE;
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    // R4: a word is released only when the stop sample was high
    assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(rx_i) && $past(tick_i)))
        else $error("word released on a low stop sample");

    // R4: a framing error only follows a low stop sample
    assert_stop_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_o |-> !$past(rx_i))
        else $error("framing error on a high stop sample");

    // R11: a stopped framer releases nothing and rests idle
    assert_gated_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!valid_o && state_q == RX_IDLE))
        else $error("framer active while disabled");
endmodule

// File: rtl/wx_host_link.sv
// Three-wire host link.
// Mode 0: data_o passes the synchronised line, and dr_o pulses on each
// validated word. Mode 1: a validated word is held and dr_o stays high.
// Each synchronised rising edge of dclk_i shifts the word right, and
// data_o shows the current LSB. After WORD_W edges the word is released.
// It assumes mode_i is synchronous to clk.
module wx_host_link
    import wx_pkg::*;
#(
    parameter int WORD_W      = DATA_BITS,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              rx_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              load_i,
    input  logic              dclk_i,
    output logic              data_o,
    output logic              dr_o
);
    localparam int BW = $clog2(WORD_W);

    logic [SYNC_STAGES:0] dclk_q;
    logic                 dclk_rise;
    logic                 pend_q;
    logic [WORD_W-1:0]    hold_q;
    logic [BW-1:0]        shcnt_q;

    // Bring the host clock into the clk domain and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) dclk_q <= '0;
        else        dclk_q <= {dclk_q[SYNC_STAGES-1:0], dclk_i};
    end

    assign dclk_rise = dclk_q[SYNC_STAGES-1] & ~dclk_q[SYNC_STAGES];

    // Hold and shift the word in host-clocked mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            hold_q  <= '0;
            shcnt_q <= '0;
        end else if (!mode_i) begin
            pend_q  <= 1'b0;
        end else if (load_i) begin
            pend_q  <= 1'b1;
            hold_q  <= word_i;
            shcnt_q <= '0;
        end else if (dclk_rise && pend_q) begin
            hold_q  <= hold_q >> 1;
            shcnt_q <= shcnt_q + 1'b1;
            if (shcnt_q == BW'(WORD_W - 1)) pend_q <= 1'b0;
        end
    end

    // Output select per mode.
    always_comb begin
        if (mode_i) begin
            data_o = pend_q ? hold_q[0] : 1'b1;
            dr_o   = pend_q;
        end else begin
            data_o = rx_i;
            dr_o   = load_i;
        end
    end

    // R6: a held word stays put until a host edge or a new word
    assert_dr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && pend_q && !load_i && !dclk_rise) |=> (pend_q && $stable(hold_q)))
        else $error("held word changed without a host edge");

    // R7: the last host edge releases the word
    assert_dr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && pend_q && !load_i && dclk_rise && shcnt_q == BW'(WORD_W - 1)) |=> !pend_q)
        else $error("data ready stuck after last bit");

    // R8: a new word replaces the held one
    assert_replace_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && load_i) |=> (pend_q && hold_q == $past(word_i) && shcnt_q == '0))
        else $error("new word not captured");
endmodule

// File: rtl/wx_msg_gate.sv
// Demodulator enable control.
// The enable starts high after reset or re-arm. It drops when carrier
// detect goes high after having been seen low. It also drops when the
// byte count announced by the second byte of the message is reached.
// Once low, it stays low until rearm_i.
module wx_msg_gate
    import wx_pkg::*;
#(
    parameter int WORD_W = DATA_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rearm_i,
    input  logic              carrier_n_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              valid_i,
    output logic              en_o
);
    logic              seen_q;
    logic              first_q;
    logic              lenok_q;
    logic [WORD_W-1:0] len_q;
    logic [WORD_W-1:0] follow_q;

    // Track carrier and message length, and drop the enable when either ends.
    always_ff @(posedge clk) begin
        if (!rst_n || rearm_i) begin
            en_o     <= 1'b1;
            seen_q   <= 1'b0;
            first_q  <= 1'b0;
            lenok_q  <= 1'b0;
            len_q    <= '0;
            follow_q <= '0;
        end else begin
            if (!carrier_n_i) seen_q <= 1'b1;
            if (seen_q && carrier_n_i) en_o <= 1'b0;
            if (valid_i && en_o) begin
                if (!first_q) begin
                    first_q <= 1'b1;
                end else if (!lenok_q) begin
                    lenok_q  <= 1'b1;
                    len_q    <= word_i;
                    follow_q <= '0;
                    if (word_i == '0) en_o <= 1'b0;
                end else begin
                    follow_q <= follow_q + 1'b1;
                    if (follow_q + 1'b1 == len_q) en_o <= 1'b0;
                end
            end
        end
    end

    // R11: a dropped enable stays dropped until re-armed
    assert_en_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !rearm_i) |=> !en_o)
        else $error("enable rose without re-arm");

    // R9: carrier loss after carrier seen drops the enable
    assert_carrier_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && carrier_n_i && !rearm_i) |=> !en_o)
        else $error("enable kept after carrier loss");

    // R9: re-arm restores the enable
    assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> en_o)
        else $error("re-arm did not enable");
endmodule

// File: rtl/demod_word_extractor.sv
// Top level of the dual-mode demodulated word extractor.
// It synchronises the serial input, frames characters at the sample rate,
// presents words on the three-wire host link, and drives the demodulator
// enable. It assumes mode_i, carrier_n_i and rearm_i are synchronous to clk.
module demod_word_extractor
    import wx_pkg::*;
#(
    parameter int CLKS_PER_SAMPLE = 4,
    parameter int OVS             = SAMPLES_PER_BIT,
    parameter int WORD_W          = DATA_BITS,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic bit_i,
    input  logic carrier_n_i,
    input  logic rearm_i,
    input  logic dclk_i,
    output logic data_o,
    output logic dr_o,
    output logic demod_en_o
);
    logic [SYNC_STAGES-1:0] rx_sync_q;
    logic                   rx_s;
    logic                   tick;
    logic [WORD_W-1:0]      word;
    logic                   word_valid;
    logic                   frame_err;

    // Synchronise the demodulated stream; the line idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sync_q <= '1;
        else        rx_sync_q <= {rx_sync_q[SYNC_STAGES-2:0], bit_i};
    end

    assign rx_s = rx_sync_q[SYNC_STAGES-1];

    wx_sample_tick #(.CLKS_PER_SAMPLE(CLKS_PER_SAMPLE)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    wx_frame_rx #(.OVS(OVS), .WORD_W(WORD_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .run_i   (demod_en_o),
        .rx_i    (rx_s),
        .word_o  (word),
        .valid_o (word_valid),
        .ferr_o  (frame_err)
    );

    wx_host_link #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .rx_i   (rx_s),
        .word_i (word),
        .load_i (word_valid),
        .dclk_i (dclk_i),
        .data_o (data_o),
        .dr_o   (dr_o)
    );

    wx_msg_gate #(.WORD_W(WORD_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .rearm_i     (rearm_i),
        .carrier_n_i (carrier_n_i),
        .word_i      (word),
        .valid_i     (word_valid),
        .en_o        (demod_en_o)
    );

    // R5: in mode 0 data ready is a single-clock pulse
    assert_mode0_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && dr_o) |=> (mode_i || !dr_o))
        else $error("mode 0 data ready longer than one clock");

    // R4: a framing error never comes with data ready in mode 0
    assert_err_no_dr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !mode_i) |-> !dr_o)
        else $error("data ready on a bad frame");
endmodule

// File: tb/demod_word_extractor_bench.sv
module demod_word_extractor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 64;   // 4 clocks per sample * 16 samples
    localparam int NV         = 6;
    // {word[7:0], stop bits[3:0], skew[1:0]}; skew 0 nominal, 1 slow, 2 fast
    localparam logic [13:0] VEC [NV] = '{
        {8'hA5, 4'd1,  2'd0},
        {8'h3C, 4'd10, 2'd0},
        {8'h01, 4'd2,  2'd1},
        {8'h80, 4'd1,  2'd2},
        {8'hFF, 4'd3,  2'd0},
        {8'h00, 4'd1,  2'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_i = 1'b0;
    logic bit_i = 1'b1;
    logic carrier_n_i = 1'b1;
    logic rearm_i = 1'b0;
    logic dclk_i = 1'b0;
    logic data_o, dr_o, demod_en_o;

    int checks = 0;
    int fails = 0;
    int pulses = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    demod_word_extractor u_demod_word_extractor (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bit_i(bit_i),
        .carrier_n_i(carrier_n_i), .rearm_i(rearm_i), .dclk_i(dclk_i),
        .data_o(data_o), .dr_o(dr_o), .demod_en_o(demod_en_o)
    );

    // Count mode 0 data-ready clocks, sampled away from the active edge.
    always @(negedge clk) if (dr_o && !mode_i) pulses++;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input int bclk);
        bit_i = b;
        repeat (bclk) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] w, input int nstop,
                              input int bclk, input bit bad_stop);
        send_bit(1'b0, bclk);
        for (int i = 0; i < 8; i++) send_bit(w[i], bclk);
        if (bad_stop) send_bit(1'b0, bclk);
        for (int i = 0; i < nstop; i++) send_bit(1'b1, bclk);
    endtask

    task automatic rearm();
        rearm_i = 1'b1;
        @(negedge clk);
        rearm_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic dclk_pulse();
        dclk_i = 1'b1;
        repeat (3) @(negedge clk);
        dclk_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Mode 1 read-out: R6 bit order, R7 release.
    task automatic read_word(input logic [7:0] exp, input string tag);
        check(dr_o === 1'b1, "R6", {tag, " data ready before read"}, dr_o, 1);
        for (int k = 0; k < 8; k++) begin
            check(data_o === exp[k], tag, $sformatf("bit %0d", k), data_o, exp[k]);
            dclk_pulse();
        end
        check(dr_o === 1'b0, "R7", "data ready after 8 edges", dr_o, 0);
        check(data_o === 1'b1, "R7", "data rests high", data_o, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        int p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        mode_i = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(dr_o === 1'b0, "R12", "dr after reset", dr_o, 0);
        check(demod_en_o === 1'b1, "R12", "enable after reset", demod_en_o, 1);
        check(data_o === 1'b1, "R12", "mode 1 idle data", data_o, 1);

        // Vector table, mode 1: R2 centre sampling and skew, R3 stop counts
        for (int v = 0; v < NV; v++) begin
            logic [7:0] w;
            int ns, bc;
            w  = VEC[v][13:6];
            ns = int'(VEC[v][5:2]);
            bc = (VEC[v][1:0] == 2'd1) ? BIT_CLKS + 1 :
                 (VEC[v][1:0] == 2'd2) ? BIT_CLKS - 1 : BIT_CLKS;
            rearm();
            send_frame(w, ns, bc, 1'b0);
            read_word(w, "R2");
        end

        // R7: extra host edges with nothing held change nothing
        dclk_pulse();
        dclk_pulse();
        check(dr_o === 1'b0, "R7", "dr after spare edges", dr_o, 0);
        check(data_o === 1'b1, "R7", "data after spare edges", data_o, 1);

        // R1: short low glitch does not start a frame
        rearm();
        send_bit(1'b0, 16);
        send_bit(1'b1, 3 * BIT_CLKS);
        check(dr_o === 1'b0, "R1", "dr after glitch", dr_o, 0);

        // R4: low stop bit discards the word, then reception resumes
        rearm();
        send_frame(8'hC3, 2, BIT_CLKS, 1'b1);
        check(dr_o === 1'b0, "R4", "dr after bad stop", dr_o, 0);
        send_frame(8'h5A, 1, BIT_CLKS, 1'b0);
        read_word(8'h5A, "R4");

        // R8: second word replaces an unread first word
        rearm();
        send_frame(8'h11, 1, BIT_CLKS, 1'b0);
        send_frame(8'h22, 2, BIT_CLKS, 1'b0);
        read_word(8'h22, "R8");

        // R5: mode 0 pass-through and single-clock pulses
        mode_i = 1'b0;
        rearm();
        bit_i = 1'b0;
        repeat (3) @(negedge clk);
        check(data_o === 1'b0, "R5", "pass-through low", data_o, 0);
        bit_i = 1'b1;
        repeat (3) @(negedge clk);
        check(data_o === 1'b1, "R5", "pass-through high", data_o, 1);
        send_bit(1'b1, 2 * BIT_CLKS);
        // R3: back-to-back frames with one stop bit each
        p0 = pulses;
        send_frame(8'h81, 1, BIT_CLKS, 1'b0);
        send_frame(8'h7E, 1, BIT_CLKS, 1'b0);
        send_frame(8'h00, 1, BIT_CLKS, 1'b0);
        send_frame(8'hFE, 1, BIT_CLKS, 1'b0);
        check(pulses - p0 == 4, "R3", "mode 0 pulse clocks for 4 frames", pulses - p0, 4);

        // R10: length byte 3, enable drops after the third following byte
        rearm();
        send_frame(8'h80, 1, BIT_CLKS, 1'b0);
        send_frame(8'h03, 1, BIT_CLKS, 1'b0);
        send_frame(8'h10, 1, BIT_CLKS, 1'b0);
        send_frame(8'h20, 1, BIT_CLKS, 1'b0);
        check(demod_en_o === 1'b1, "R10", "enable before last byte", demod_en_o, 1);
        send_frame(8'h30, 1, BIT_CLKS, 1'b0);
        check(demod_en_o === 1'b0, "R10", "enable after last byte", demod_en_o, 0);
        // R11: frames ignored while disabled, enable stays low
        p0 = pulses;
        send_frame(8'h44, 2, BIT_CLKS, 1'b0);
        check(pulses == p0, "R11", "pulses while disabled", pulses - p0, 0);
        check(demod_en_o === 1'b0, "R11", "enable stays low", demod_en_o, 0);
        rearm();
        check(demod_en_o === 1'b1, "R9", "enable after re-arm", demod_en_o, 1);

        // R10: zero length drops the enable right after the length byte
        send_frame(8'h80, 1, BIT_CLKS, 1'b0);
        send_frame(8'h00, 1, BIT_CLKS, 1'b0);
        check(demod_en_o === 1'b0, "R10", "enable after zero length", demod_en_o, 0);

        // R9: carrier present then lost
        rearm();
        carrier_n_i = 1'b0;
        repeat (4) @(negedge clk);
        check(demod_en_o === 1'b1, "R9", "enable with carrier", demod_en_o, 1);
        carrier_n_i = 1'b1;
        repeat (3) @(negedge clk);
        check(demod_en_o === 1'b0, "R9", "enable after carrier loss", demod_en_o, 0);
        rearm();
        repeat (3) @(negedge clk);
        check(demod_en_o === 1'b1, "R9", "re-arm without carrier", demod_en_o, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule